// File: doc/BRIEF.md
# Serial-to-Parallel Bit-Reversed Frame Loader

This block sits in front of an 8-point radix-2 decimation-in-time FFT whose first stage takes all of its operands at once. Complex samples arrive one per accepted cycle on a valid/ready stream. Each sample has a real word and an imaginary word. The block gathers each run of eight samples into a frame and stores every sample at the bit-reversed copy of its arrival index. When a frame is complete, the eight samples appear together on two wide output buses, one for real parts and one for imaginary parts. The samples are already in the order the first butterfly stage expects: arrival indices 0, 4, 2, 6, 1, 5, 3, 7 in slots 0 through 7.

Storage is split into two banks that take turns. One bank fills from the stream while the other drives the outputs. The banks swap roles when the last sample of a frame is written. A new frame can therefore start on the very next cycle, and the previous frame stays visible until the following frame replaces it. A single-cycle strobe tells the FFT that a fresh frame is on the buses.

The input side never applies back-pressure. `in_ready` is low while reset is held and during the first clock after reset is released, and it is high from then on. A sample is taken on every rising edge where both `in_valid` and `in_ready` are high. There is no output-side ready, because the FFT accepts a frame on any cycle.

Top module: `bitrev_frame_loader`

## Requirements
- R1: While `rst_n` is low, `frame_valid` and `in_ready` are low and every output slot reads zero. The first sample accepted after reset is arrival index 0 of a new frame.
- R2: `in_ready` goes high at the first rising edge after `rst_n` is released and stays high. A sample is taken on every rising edge where both `in_valid` and `in_ready` are high.
- R3: A cycle with `in_valid` low does not advance the frame position. Its data does not reach any output, and the outputs do not change.
- R4: Output slot j occupies bits [24j+23 : 24j] of `out_re` and `out_im`. It carries the sample whose arrival index, counted from 0 within the frame, is the 3-bit reversal of j. Slots 0 to 7 therefore hold arrival indices 0, 4, 2, 6, 1, 5, 3, 7.
- R5: The real and imaginary parts travel the same path. Each part passes through unchanged as a full 24-bit two's-complement word, including the most negative value 0x800000 and the most positive value 0x7FFFFF.
- R6: `frame_valid` is high for exactly one cycle. That cycle is the one after the rising edge that accepts the eighth sample of a frame. The new frame is on the outputs in the same cycle.
- R7: Between strobes, the output buses hold the last completed frame unchanged while the next frame is being collected.
- R8: Frames may follow each other with no idle cycle. With `in_valid` held high, a strobe appears every eight cycles and no sample is lost or misplaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered on `in_re`/`in_im` |
| in_ready | output | 1 | The block takes the offered sample this cycle |
| in_re | input | 24 | Real part of the offered sample, signed |
| in_im | input | 24 | Imaginary part of the offered sample, signed |
| frame_valid | output | 1 | One-cycle strobe marking a new parallel frame |
| out_re | output | 192 | Real parts of the held frame, slot j in bits [24j+23:24j] |
| out_im | output | 192 | Imaginary parts of the held frame, slot j in bits [24j+23:24j] |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The eighth accepted sample raises `frame_valid` and puts the new frame on the buses after that single register stage. `in_ready` rises one edge after reset is released. The bench drives inputs on falling edges and checks the outputs at the next falling edge, before it drives the next input, so each comparison sees the state from exactly one edge later. On every cycle without a strobe, the bench also compares all sixteen slot values with the last frame it expects to be held. This catches any output that moves early, moves late or is corrupted by an ignored input.

// File: rtl/blr_pkg.sv
package blr_pkg;

  // Which of the two storage banks is currently filling from the stream.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // Defaults used by the top level.
  localparam int unsigned BLR_DATA_W    = 24;
  localparam int unsigned BLR_FRAME_LEN = 8;

endpackage

// File: rtl/blr_index_ctrl.sv
module blr_index_ctrl
  import blr_pkg::*;
#(
  parameter int unsigned FRAME_LEN = BLR_FRAME_LEN,
  localparam int unsigned IDXW     = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  output logic [IDXW-1:0] wr_addr,
  output logic            wr_bank,
  output logic            frame_done
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_LEN - 1);

  logic [IDXW-1:0] idx_q;
  bank_e           bank_q;
  logic            done_q;
  logic            wrap;

  assign wrap = accept && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bank_q <= BANK_A;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap;
      if (accept) begin
        idx_q <= wrap ? '0 : idx_q + 1'b1;
      end
      if (wrap) begin
        bank_q <= (bank_q == BANK_A) ? BANK_B : BANK_A;
      end
    end
  end

  // The write address is the arrival counter with its bits mirrored.
  for (genvar b = 0; b < IDXW; b++) begin : g_rev
    assign wr_addr[b] = idx_q[IDXW-1-b];
  end

  assign wr_bank    = bank_q;
  assign frame_done = done_q;

  // R3
  idle_holds_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(idx_q));

  // R6
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  strobe_at_frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (idx_q == '0) && (bank_q != $past(bank_q)));

endmodule

// File: rtl/blr_bank_store.sv
module blr_bank_store #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned IDXW     = $clog2(FRAME_LEN),
  localparam int unsigned BUS_W    = DATA_W * FRAME_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wr_bank,
  input  logic [IDXW-1:0]   wr_addr,
  input  logic [DATA_W-1:0] din,
  output logic [BUS_W-1:0]  dout
);

  logic [DATA_W-1:0] mem [2][FRAME_LEN];
  logic              rd_bank;

  assign rd_bank = ~wr_bank;

  for (genvar bk = 0; bk < 2; bk++) begin : g_bank
    for (genvar s = 0; s < FRAME_LEN; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem[bk][s] <= '0;
        end else if (we && (wr_bank == 1'(bk)) && (wr_addr == IDXW'(s))) begin
          mem[bk][s] <= din;
        end
      end
    end
  end

  for (genvar s = 0; s < FRAME_LEN; s++) begin : g_out
    assign dout[s*DATA_W +: DATA_W] = mem[rd_bank][s];
  end

  // R7
  held_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_bank) |-> $stable(dout));

endmodule

// File: rtl/bitrev_frame_loader.sv
module bitrev_frame_loader
  import blr_pkg::*;
#(
  parameter int unsigned DATA_W    = BLR_DATA_W,
  parameter int unsigned FRAME_LEN = BLR_FRAME_LEN,
  localparam int unsigned IDXW     = $clog2(FRAME_LEN),
  localparam int unsigned BUS_W    = DATA_W * FRAME_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              frame_valid,
  output logic [BUS_W-1:0]  out_re,
  output logic [BUS_W-1:0]  out_im
);

  logic            ready_q;
  logic            accept;
  logic [IDXW-1:0] wr_addr;
  logic            wr_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  blr_index_ctrl #(
    .FRAME_LEN (FRAME_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wr_addr    (wr_addr),
    .wr_bank    (wr_bank),
    .frame_done (frame_valid)
  );

  // The real and imaginary parts use identical storage paths.
  for (genvar p = 0; p < 2; p++) begin : g_part
    logic [DATA_W-1:0] part_in;
    logic [BUS_W-1:0]  part_out;

    assign part_in = (p == 0) ? in_re : in_im;

    blr_bank_store #(
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (accept),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .din     (part_in),
      .dout    (part_out)
    );
  end

  assign out_re = g_part[0].part_out;
  assign out_im = g_part[1].part_out;

  // R2
  ready_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R3
  no_strobe_without_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !frame_valid);

  // R7
  outputs_quiet_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(out_re) && $stable(out_im));

endmodule

// File: tb/bitrev_frame_loader_tb.sv
module bitrev_frame_loader_tb;

  localparam int W = 24;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [W-1:0]   in_re;
  logic [W-1:0]   in_im;
  logic           frame_valid;
  logic [W*N-1:0] out_re;
  logic [W*N-1:0] out_im;

  always #2 clk = ~clk;

  bitrev_frame_loader u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_re       (in_re),
    .in_im       (in_im),
    .frame_valid (frame_valid),
    .out_re      (out_re),
    .out_im      (out_im)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // Model of the block: samples of the frame in collection, by arrival.
  logic [W-1:0] pend_re [N];
  logic [W-1:0] pend_im [N];
  logic [W-1:0] done_re [N];
  logic [W-1:0] done_im [N];
  logic [W-1:0] held_re [N];
  logic [W-1:0] held_im [N];
  int  pend_cnt = 0;
  bit  fv_due   = 0;

  function automatic int rev3(input int j);
    return ((j & 1) << 2) | (j & 2) | ((j >> 2) & 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < N; j++) begin
      held_re[j] = '0;
      held_im[j] = '0;
    end
    pend_cnt = 0;
    fv_due   = 0;
  endtask

  // Runs at a falling edge: compares the state left by the previous rising edge.
  task automatic check_cycle();
    string req;
    check(in_ready === 1'b1, "R2", "in_ready", W'(in_ready), W'(1));
    check(frame_valid === fv_due, "R6", "frame_valid", W'(frame_valid), W'(fv_due));
    if (fv_due) begin
      for (int j = 0; j < N; j++) begin
        held_re[j] = done_re[rev3(j)];
        held_im[j] = done_im[rev3(j)];
      end
      req = "R4";
    end else begin
      req = "R7";
    end
    fv_due = 0;
    for (int j = 0; j < N; j++) begin
      check(out_re[j*W +: W] === held_re[j], req, $sformatf("out_re slot %0d", j),
            out_re[j*W +: W], held_re[j]);
      check(out_im[j*W +: W] === held_im[j], req, $sformatf("out_im slot %0d", j),
            out_im[j*W +: W], held_im[j]);
    end
  endtask

  task automatic drive(input bit v, input logic [W-1:0] re, input logic [W-1:0] im);
    @(negedge clk);
    check_cycle();
    in_valid = v;
    in_re    = re;
    in_im    = im;
    if (v) begin
      pend_re[pend_cnt] = re;
      pend_im[pend_cnt] = im;
      pend_cnt++;
      if (pend_cnt == N) begin
        for (int j = 0; j < N; j++) begin
          done_re[j] = pend_re[j];
          done_im[j] = pend_im[j];
        end
        pend_cnt = 0;
        fv_due   = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, W'(24'h5A5A5A + i), W'(24'hA5A5A5 - i));
  endtask

  // R1: reset state and clean restart
  task automatic t_reset();
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_re    = 24'h123456;
    in_im    = 24'h654321;
    repeat (3) @(negedge clk);
    check(frame_valid === 1'b0, "R1", "frame_valid in reset", W'(frame_valid), W'(0));
    check(in_ready === 1'b0, "R1", "in_ready in reset", W'(in_ready), W'(0));
    check(out_re === '0, "R1", "out_re in reset", out_re[W-1:0], W'(0));
    check(out_im === '0, "R1", "out_im in reset", out_im[W-1:0], W'(0));
    in_valid = 1'b0;
    rst_n    = 1'b1;
    model_reset();
  endtask

  // R4: single ramp frame, bit-reversed placement
  task automatic t_single_frame();
    for (int i = 0; i < N; i++) drive(1'b1, W'(16 + i), W'(100 + 3*i));
    idle(3);
  endtask

  // R5: extreme signed values on both parts
  task automatic t_extremes();
    logic [W-1:0] vals [N];
    vals[0] = 24'h800000; vals[1] = 24'h7FFFFF; vals[2] = 24'hFFFFFF; vals[3] = 24'h000001;
    vals[4] = 24'hC00000; vals[5] = 24'h3FFFFF; vals[6] = 24'h800001; vals[7] = 24'h000000;
    for (int i = 0; i < N; i++) drive(1'b1, vals[i], vals[N-1-i]);
    idle(2);
    // R5 explicit: slot 1 holds arrival 4, slot 4 holds arrival 1
    check(out_re[1*W +: W] === 24'hC00000, "R5", "slot1 real", out_re[1*W +: W], 24'hC00000);
    check(out_im[4*W +: W] === 24'h800001, "R5", "slot4 imag", out_im[4*W +: W], 24'h800001);
  endtask

  // R3: idle cycles with changing data in the middle of a frame
  task automatic t_gaps();
    for (int i = 0; i < N; i++) begin
      drive(1'b1, W'(24'h400000 + 7*i), W'(24'hB00000 - 11*i));
      if (i % 3 == 1) idle(2);
    end
    idle(4);
  endtask

  // R8: back-to-back frames with in_valid held high
  task automatic t_back_to_back();
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < N; i++)
        drive(1'b1, W'(f*4096 + i*29 - 1000), W'(-(f*777) + i*13));
    idle(3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    @(negedge clk);
    t_single_frame();
    t_extremes();
    t_gaps();
    t_back_to_back();
    // R1 again: a reset mid-frame restarts the arrival count at 0
    for (int i = 0; i < 3; i++) drive(1'b1, W'(24'h0F0F0F), W'(24'hF0F0F0));
    t_reset();
    @(negedge clk);
    t_single_frame();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule